// File: doc/BRIEF.md
# Serial-Clock Pulse-Pattern Reset Detector

This block watches the serial clock of a slave serial port and recognises a deliberate out-of-band reset request written on that clock line. The request is three long high phases separated by low gaps. Each high phase must fall inside its own duration window, measured in periods of the local master clock. Ordinary data-transfer clock pulses are far shorter than any window, so they can never produce a request.

The raw serial clock and the active-low chip select are brought into the master-clock domain by a two-flop synchroniser. A phase timer then measures how long each high or low level lasts. A small sequencer checks each completed high phase against the window for the pulse it expects next, and checks each low gap against a minimum length. When the third pulse ends inside its window, the block raises a one-cycle reset request, which the rest of the serial interface acts on. The sequencer's progress is visible on a debug output. All ports are plain control and status signals; there is no data stream and no handshake.

Top module: `sclk_pattern_reset_det`

## Requirements
- R1: While `rst_n` is low, `reset_req` is 0 and `dbg_state` is 0. This holds at once on assertion of reset, even in the middle of a pattern.
- R2: The first pulse of a pattern is accepted only if its high time is 300 to 500 master-clock cycles, both limits included.
- R3: The second pulse is accepted only if its high time is 550 to 750 cycles, both limits included.
- R4: The third pulse completes the pattern only if its high time is 1050 to 1250 cycles, both limits included.
- R5: Each low gap after an accepted pulse must last at least 5 cycles. A shorter gap returns the sequencer to idle at the next rising edge, and the pulse that starts there is judged as a possible first pulse.
- R6: A pulse that misses the window for the pulse expected next is judged again against the first-pulse window. If it fits, the pattern restarts with it as the first pulse (`dbg_state` = 1); otherwise the sequencer goes to idle.
- R7: The phase timer saturates at 1251 cycles, so a high phase of any length above 1250 cycles is rejected by every window.
- R8: `reset_req` is high for exactly one master-clock cycle. It rises at the third rising edge of `clk` after the serial clock falls at the end of an accepted third pulse, and it is 0 at the two edges before that.
- R9: While the synchronised `cs_n` is high, the sequencer is held in idle and `reset_req` stays 0. Raising `cs_n` in the middle of a pattern discards the progress made so far.
- R10: `dbg_state` encodes the sequencer's progress as 0 = idle, 1 = first pulse accepted, 2 = second pulse accepted. It changes at the same edge that `reset_req` would, three `clk` rising edges after a serial-clock fall.
- R11: Short serial-clock pulses, such as 8-cycle high and 4-cycle low, never raise `reset_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; every duration is counted in its periods |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low; high holds the detector idle |
| sclk | input | 1 | Raw serial clock, asynchronous to `clk` |
| reset_req | output | 1 | One-cycle request to reset the serial interface |
| dbg_state | output | 2 | Sequencer progress: 0 idle, 1 first pulse accepted, 2 second pulse accepted |

## Verification
The hardest situation to reach from the ports is a pulse that fails the window for the pulse expected next but still fits the first-pulse window. To reach it, the bench first has to be in the middle of a valid pattern. It therefore sends an accepted first pulse and then a second pulse of 420 cycles, and checks that the sequencer restarts with that pulse instead of dropping to idle. Two other cases need long, deliberate waveforms. One is a counter held at saturation by a 3000-cycle high phase. The other is chip select raised after two good pulses, followed by a third pulse that would otherwise have completed the pattern. Every window edge is probed one cycle inside and one cycle outside, in a table of vectors.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HAVE1 = 2'd1,
    ST_HAVE2 = 2'd2
  } spr_state_e;

  // inclusive range test on a measured phase length
  function automatic logic in_window(input logic [31:0] len,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (len >= lo) && (len <= hi);
  endfunction

endpackage

// File: rtl/spr_sync.sv
module spr_sync #(
  parameter int unsigned     WIDTH   = 2,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
        else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spr_phase_timer.sv
module spr_phase_timer #(
  parameter int unsigned SAT = 1251,
  localparam int unsigned CW = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  output logic          rise,
  output logic          fall,
  output logic [CW-1:0] width
);

  logic          lvl_d;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      cnt   <= '0;
    end else begin
      lvl_d <= lvl;
      if (lvl != lvl_d)        cnt <= CW'(1);
      else if (cnt != CW'(SAT)) cnt <= cnt + CW'(1);
    end
  end

  assign rise  = lvl & ~lvl_d;
  assign fall  = ~lvl & lvl_d;
  assign width = cnt;

  // R7: the count never exceeds the saturation value
  assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    width <= CW'(SAT));

  // R7: once saturated, a steady level keeps the count pinned
  assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (width == CW'(SAT) && !rise && !fall) |=> (width == CW'(SAT)));

endmodule

// File: rtl/spr_seq_fsm.sv
module spr_seq_fsm
  import spr_pkg::*;
#(
  parameter int unsigned CW      = 11,
  parameter int unsigned P1_LO   = 300,
  parameter int unsigned P1_HI   = 500,
  parameter int unsigned P2_LO   = 550,
  parameter int unsigned P2_HI   = 750,
  parameter int unsigned P3_LO   = 1050,
  parameter int unsigned P3_HI   = 1250,
  parameter int unsigned GAP_MIN = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          rise,
  input  logic          fall,
  input  logic [CW-1:0] width,
  output logic          req,
  output spr_state_e    state
);

  spr_state_e  nxt;
  logic        nreq;
  logic [31:0] w32;
  logic        ok1, ok2, ok3;

  assign w32 = 32'(width);
  assign ok1 = in_window(w32, P1_LO, P1_HI);
  assign ok2 = in_window(w32, P2_LO, P2_HI);
  assign ok3 = in_window(w32, P3_LO, P3_HI);

  always_comb begin
    nxt  = state;
    nreq = 1'b0;
    if (!cs_act) begin
      nxt = ST_IDLE;
    end else if (rise && state != ST_IDLE && w32 < GAP_MIN) begin
      nxt = ST_IDLE;
    end else if (fall) begin
      case (state)
        ST_IDLE:  nxt = ok1 ? ST_HAVE1 : ST_IDLE;
        ST_HAVE1: nxt = ok2 ? ST_HAVE2 : (ok1 ? ST_HAVE1 : ST_IDLE);
        ST_HAVE2: begin
          if (ok3) begin
            nreq = 1'b1;
            nxt  = ST_IDLE;
          end else begin
            nxt = ok1 ? ST_HAVE1 : ST_IDLE;
          end
        end
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      req   <= 1'b0;
    end else begin
      state <= nxt;
      req   <= nreq;
    end
  end

  // R8: the request never lasts two cycles
  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);

  // R8: a request only follows a falling edge seen with two pulses accepted
  assert_req_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> ($past(state) == ST_HAVE2 && $past(fall)));

  // R9: chip select deasserted forces idle and no request
  assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (state == ST_IDLE && !req));

  // R5: a short gap after an accepted pulse drops to idle
  assert_short_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && rise && state != ST_IDLE && w32 < GAP_MIN) |=> (state == ST_IDLE));

  // R10: only the three legal encodings appear
  assert_state_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state != 2'd3);

endmodule

// File: rtl/sclk_pattern_reset_det.sv
module sclk_pattern_reset_det
  import spr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned P1_LO       = 300,
  parameter int unsigned P1_HI       = 500,
  parameter int unsigned P2_LO       = 550,
  parameter int unsigned P2_HI       = 750,
  parameter int unsigned P3_LO       = 1050,
  parameter int unsigned P3_HI       = 1250,
  parameter int unsigned GAP_MIN     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  output logic       reset_req,
  output logic [1:0] dbg_state
);

  localparam int unsigned CNT_SAT = P3_HI + 1;
  localparam int unsigned CW      = $clog2(CNT_SAT + 1);

  logic [1:0]    synced;
  logic          rise, fall;
  logic [CW-1:0] width;
  spr_state_e    state;

  spr_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b10)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk}),
    .q     (synced)
  );

  spr_phase_timer #(
    .SAT (CNT_SAT)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (synced[0]),
    .rise  (rise),
    .fall  (fall),
    .width (width)
  );

  spr_seq_fsm #(
    .CW      (CW),
    .P1_LO   (P1_LO),
    .P1_HI   (P1_HI),
    .P2_LO   (P2_LO),
    .P2_HI   (P2_HI),
    .P3_LO   (P3_LO),
    .P3_HI   (P3_HI),
    .GAP_MIN (GAP_MIN)
  ) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_act (~synced[1]),
    .rise   (rise),
    .fall   (fall),
    .width  (width),
    .req    (reset_req),
    .state  (state)
  );

  assign dbg_state = state;

endmodule

// File: tb/sim_sclk_pattern_reset_det.sv
`timescale 1ns/1ps
module sim_sclk_pattern_reset_det;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b0;
  logic       sclk = 1'b0;
  logic       reset_req;
  logic [1:0] dbg_state;

  int n_chk = 0;
  int n_bad = 0;
  int req_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sclk_pattern_reset_det u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sclk      (sclk),
    .reset_req (reset_req),
    .dbg_state (dbg_state)
  );

  always @(negedge clk) if (reset_req) req_cnt++;

  localparam int NV = 12;
  // columns: first high, second high, third high, low gap, requests expected, requirement tag
  localparam int V_H1 [NV] = '{400, 300, 500, 299, 501, 400, 400, 400, 400, 400,   8,  400};
  localparam int V_H2 [NV] = '{650, 550, 750, 650, 650, 549, 751, 650, 650, 650,   8,  650};
  localparam int V_H3 [NV] = '{1150,1050,1250,1150,1150,1150,1150,1049,1251,1150,  8, 3000};
  localparam int V_GAP[NV] = '{ 10,   5,   5,  10,  10,  10,  10,  10,  10,   4,   4,   10};
  localparam int V_EXP[NV] = '{  1,   1,   1,   0,   0,   0,   0,   0,   0,   0,   0,    0};
  // tags: R2 nominal, R2 low limits, R4 high limits, R2 below, R2 above, R3 below,
  //       R3 above, R4 below, R4 above, R5 gap, R11 short clocks, R7 saturation
  localparam int V_TAG[NV] = '{  2,   2,   4,   2,   2,   3,   3,   4,   4,   5,  11,    7};

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    sclk = 1'b1;
    repeat (hi) @(negedge clk);
    sclk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 reset req", int'(reset_req), 0);
    check("R1 reset state", int'(dbg_state), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 after release state", int'(dbg_state), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      req_cnt = 0;
      pulse(V_H1[i], V_GAP[i]);
      pulse(V_H2[i], V_GAP[i]);
      pulse(V_H3[i], 20);
      check($sformatf("R%0d vector %0d requests", V_TAG[i], i), req_cnt, V_EXP[i]);
      check($sformatf("R%0d vector %0d end state", V_TAG[i], i), int'(dbg_state), 0);
    end

    // R8 / R10 exact timing
    req_cnt = 0;
    sclk = 1'b1; repeat (400) @(negedge clk); sclk = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R10 state before third edge", int'(dbg_state), 0);
    @(posedge clk); #1;
    check("R10 state after first pulse", int'(dbg_state), 1);
    repeat (8) @(negedge clk);
    sclk = 1'b1; repeat (650) @(negedge clk); sclk = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R10 state after second pulse", int'(dbg_state), 2);
    repeat (8) @(negedge clk);
    sclk = 1'b1; repeat (1150) @(negedge clk); sclk = 1'b0;
    repeat (2) @(posedge clk); #1;
    check("R8 request not early", int'(reset_req), 0);
    @(posedge clk); #1;
    check("R8 request at third edge", int'(reset_req), 1);
    check("R10 idle with request", int'(dbg_state), 0);
    @(posedge clk); #1;
    check("R8 request one cycle", int'(reset_req), 0);
    repeat (10) @(negedge clk);
    check("R8 single request counted", req_cnt, 1);

    // R6 re-examination
    req_cnt = 0;
    pulse(400, 10);
    pulse(420, 10);
    check("R6 miss fits first window", int'(dbg_state), 1);
    pulse(650, 10);
    check("R6 second after restart", int'(dbg_state), 2);
    pulse(1150, 10);
    check("R6 restarted pattern completes", req_cnt, 1);
    pulse(400, 10);
    pulse(100, 10);
    check("R6 miss fits no window", int'(dbg_state), 0);

    // R9 chip select
    req_cnt = 0;
    pulse(400, 10);
    pulse(650, 10);
    check("R9 progress before deselect", int'(dbg_state), 2);
    cs_n = 1'b1; repeat (6) @(negedge clk);
    check("R9 deselect clears state", int'(dbg_state), 0);
    cs_n = 1'b0; repeat (4) @(negedge clk);
    pulse(1150, 10);
    check("R9 no request after discard", req_cnt, 0);
    cs_n = 1'b1; repeat (4) @(negedge clk);
    pulse(400, 10); pulse(650, 10); pulse(1150, 10);
    check("R9 no request while deselected", req_cnt, 0);
    check("R9 state while deselected", int'(dbg_state), 0);
    cs_n = 1'b0; repeat (4) @(negedge clk);

    // R1 asynchronous reset mid-pattern
    pulse(400, 10);
    check("R1 progress before reset", int'(dbg_state), 1);
    rst_n = 1'b0; #1;
    check("R1 async reset state", int'(dbg_state), 0);
    check("R1 async reset req", int'(reset_req), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule